// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the device-side command interpreter of a serial NOR flash. It watches the chip-select, serial clock and serial data-in pins and assembles bytes from them. It decodes the first byte of each frame as an opcode and answers on the data-out pin. It keeps two 8-bit status registers and a write-enable latch. It returns the status bytes and a three-byte identification string. It hands program and erase requests to the memory core's sequencer through a request/acknowledge port.

The pins are oversampled by the system clock. A short synchronizer feeds an edge detector, so the serial clock must stay well below a quarter of the system clock. The interface runs in SPI mode 0. A modifying command takes effect only when chip-select rises on a byte boundary after a complete frame. Page-program data bytes are streamed to the core as they arrive. The core keeps them in its page buffer until the request commits them.

Top module: `spi_flash_cmd`

## Requirements
- R1: After reset spi_miso is 0 and core_req is 0, and both status registers read 00h.
- R2: The first byte of a frame (chip-select low) is the opcode. Data-in is sampled on the rising serial-clock edge, most significant bit first. Data-out changes after the falling edge, most significant bit first. Data-out is 0 during the opcode byte and while chip-select is high.
- R3: Opcode 05h returns status register 1, laid out as {stored bits 7:2, WEL in bit 1, BUSY in bit 0}. Opcode 35h returns status register 2. The chosen register is sent again for every further byte while chip-select stays low.
- R4: Opcode 9Fh returns the MFR_ID, TYPE_ID and CAP_ID parameters in that order, and 00h for every later byte.
- R5: Opcode 06h sets WEL when the frame ends on a byte boundary.
- R6: Opcode 01h with WEL set writes its first data byte's bits 7:2 into status register 1 and its second data byte into status register 2. The write happens when chip-select rises on a byte boundary, and it clears WEL. With WEL clear the opcode changes nothing.
- R7: Opcodes 20h, 52h and D8h take three address bytes, MSB first. Opcodes C7h and 60h take none. A complete frame raises core_req with core_op 1, 2, 3 or 4 (4 for both chip-erase opcodes) and clears WEL. A byte beyond the frame cancels the command.
- R8: Opcode 02h with three address bytes pulses pgm_vld with pgm_data once per following data byte. At least one data byte commits it, as core_op 0.
- R9: A modifying opcode (01h, 02h, 20h, 52h, D8h, C7h, 60h) sent while WEL is clear issues nothing.
- R10: Chip-select rising inside a byte, or before the frame is complete, issues nothing and leaves WEL unchanged.
- R11: BUSY is core_busy OR a pending request. While BUSY is set only 05h and 35h are answered. 9Fh returns 00h, 06h has no effect and modifying opcodes are ignored.
- R12: core_req, core_op and core_addr stay unchanged until core_ack is sampled high. core_req then falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock (mode 0) |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out of the device |
| core_req | output | 1 | Program/erase request to the sequencer |
| core_op | output | 3 | 0 program, 1 4 KB erase, 2 32 KB erase, 3 64 KB erase, 4 full erase |
| core_addr | output | ADDR_W | Target address of the request |
| core_ack | input | 1 | Sequencer accepts the request |
| core_busy | input | 1 | Sequencer is executing an operation |
| pgm_vld | output | 1 | One-cycle strobe for a page-program data byte |
| pgm_data | output | 8 | Page-program data byte |

## Verification
The bench uses the default parameters: a 24-bit address, two synchronizer stages and the default identification bytes. With these the full three-byte address frame and the whole ID string are covered. The serial clock runs with a half period of eight system clocks. That spacing leaves room for the synchronizer and edge-detect latency, so each data-out bit is stable before the bench samples it. It also makes aborts inside a byte simple to place at exact bit positions.

// File: rtl/spi_flash_cmd_pkg.sv
package spi_flash_cmd_pkg;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_RDSR1 = 8'h05;
  localparam logic [7:0] OPC_RDSR2 = 8'h35;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_RDID  = 8'h9F;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_ER4K  = 8'h20;
  localparam logic [7:0] OPC_ER32K = 8'h52;
  localparam logic [7:0] OPC_ER64K = 8'hD8;
  localparam logic [7:0] OPC_ERALA = 8'hC7;
  localparam logic [7:0] OPC_ERALB = 8'h60;

  typedef enum logic [2:0] {
    CORE_PROG      = 3'd0,
    CORE_ERASE_4K  = 3'd1,
    CORE_ERASE_32K = 3'd2,
    CORE_ERASE_64K = 3'd3,
    CORE_ERASE_ALL = 3'd4
  } core_op_e;

  typedef enum logic [3:0] {
    PH_OPC, PH_WREN, PH_STAT, PH_ID, PH_WRSR,
    PH_ADDR, PH_PDATA, PH_ERDY, PH_IGN
  } phase_e;

endpackage

// File: rtl/sfc_pin_sync.sv
module sfc_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sclk,
  input  logic spi_mosi,
  output logic cs_s,
  output logic cs_rise,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);

  logic [SYNC_STAGES-1:0] cs_pipe, sclk_pipe, mosi_pipe;
  logic cs_prev, sclk_prev;
  logic sclk_s;

  // Same depth on every pin keeps data aligned with its clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe   <= '1;
      sclk_pipe <= '0;
      mosi_pipe <= '0;
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], spi_cs_n};
      sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], spi_sclk};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], spi_mosi};
      cs_prev   <= cs_s;
      sclk_prev <= sclk_s;
    end
  end

  assign cs_s      = cs_pipe[SYNC_STAGES-1];
  assign sclk_s    = sclk_pipe[SYNC_STAGES-1];
  assign mosi_s    = mosi_pipe[SYNC_STAGES-1];
  assign cs_rise   = cs_s & ~cs_prev;
  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;

endmodule

// File: rtl/sfc_byte_io.sv
module sfc_byte_io (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_s,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       rx_done,
  output logic       at_boundary,
  output logic       miso
);

  logic [2:0] bit_q, bit_d;
  logic [6:0] rxs_q, rxs_d;
  logic [7:0] rxb_q, rxb_d;
  logic       done_q, done_d;
  logic [7:0] txs_q, txs_d;

  always_comb begin
    bit_d  = bit_q;
    rxs_d  = rxs_q;
    rxb_d  = rxb_q;
    done_d = 1'b0;
    txs_d  = txs_q;
    if (cs_s) begin
      bit_d = '0;
      txs_d = '0;
    end else begin
      if (sclk_rise) begin
        rxs_d = {rxs_q[5:0], mosi_s};
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          rxb_d  = {rxs_q, mosi_s};
          done_d = 1'b1;
        end
      end
      if (sclk_fall) begin
        // A new response byte is loaded on the first falling edge of each byte.
        txs_d = (bit_q == 3'd0) ? tx_byte : {txs_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rxs_q  <= '0;
      rxb_q  <= '0;
      done_q <= 1'b0;
      txs_q  <= '0;
    end else begin
      bit_q  <= bit_d;
      rxs_q  <= rxs_d;
      rxb_q  <= rxb_d;
      done_q <= done_d;
      txs_q  <= txs_d;
    end
  end

  assign rx_byte     = rxb_q;
  assign rx_done     = done_q;
  assign at_boundary = (bit_q == 3'd0);
  assign miso        = txs_q[7] & ~cs_s;

endmodule

// File: rtl/sfc_cmd_fsm.sv
module sfc_cmd_fsm
  import spi_flash_cmd_pkg::*;
#(
  parameter int          ADDR_W  = 24,
  parameter logic [7:0]  MFR_ID  = 8'hA7,
  parameter logic [7:0]  TYPE_ID = 8'h40,
  parameter logic [7:0]  CAP_ID  = 8'h15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              cs_rise,
  input  logic              rx_done,
  input  logic [7:0]        rx_byte,
  input  logic              at_boundary,
  input  logic              core_busy,
  input  logic              core_ack,
  output logic [7:0]        tx_byte,
  output logic              core_req,
  output core_op_e          core_op,
  output logic [ADDR_W-1:0] core_addr,
  output logic              pgm_vld,
  output logic [7:0]        pgm_data,
  output logic              wel
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int ACNT_W     = $clog2(ADDR_BYTES + 1);

  phase_e            phase_q, phase_d;
  core_op_e          op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ACNT_W-1:0] acnt_q, acnt_d;
  logic [1:0]        dcnt_q, dcnt_d;
  logic              sel2_q, sel2_d;
  logic [1:0]        idx_q, idx_d;
  logic [5:0]        hi_q, hi_d, w1_q, w1_d;
  logic [7:0]        sr2_q, sr2_d, w2_q, w2_d;
  logic              wel_q, wel_d, req_q, req_d, pv_q, pv_d;
  logic [7:0]        tx_q, tx_d, pd_q, pd_d;
  logic              busy;
  logic [7:0]        sr1;
  logic              may_modify;

  assign busy       = core_busy | req_q;
  assign sr1        = {hi_q, wel_q, busy};
  assign may_modify = wel_q & ~busy;

  always_comb begin
    phase_d = phase_q; op_d = op_q; addr_d = addr_q; acnt_d = acnt_q;
    dcnt_d = dcnt_q; sel2_d = sel2_q; idx_d = idx_q; hi_d = hi_q;
    sr2_d = sr2_q; w1_d = w1_q; w2_d = w2_q; wel_d = wel_q;
    req_d = req_q; tx_d = tx_q; pv_d = 1'b0; pd_d = pd_q;
    if (req_q && core_ack) req_d = 1'b0;
    if (cs_s) begin
      phase_d = PH_OPC; acnt_d = '0; dcnt_d = '0; idx_d = '0; tx_d = '0;
      if (cs_rise && at_boundary) begin
        case (phase_q)
          PH_WREN: wel_d = 1'b1;
          PH_WRSR: if (dcnt_q != 2'd0) begin
            hi_d  = w1_q;
            if (dcnt_q == 2'd2) sr2_d = w2_q;
            wel_d = 1'b0;
          end
          PH_ERDY: begin req_d = 1'b1; wel_d = 1'b0; end
          PH_PDATA: if (dcnt_q != 2'd0) begin req_d = 1'b1; wel_d = 1'b0; end
          default: ;
        endcase
      end
    end else if (rx_done) begin
      case (phase_q)
        PH_OPC: begin
          phase_d = PH_IGN;
          if (rx_byte == OPC_RDSR1 || rx_byte == OPC_RDSR2) begin
            phase_d = PH_STAT;
            sel2_d  = (rx_byte == OPC_RDSR2);
            tx_d    = (rx_byte == OPC_RDSR2) ? sr2_q : sr1;
          end else if (!busy) begin
            if (rx_byte == OPC_WREN) phase_d = PH_WREN;
            else if (rx_byte == OPC_RDID) begin
              phase_d = PH_ID; tx_d = MFR_ID; idx_d = 2'd1;
            end else if (may_modify) begin
              if (rx_byte == OPC_WRSR) phase_d = PH_WRSR;
              else if (rx_byte == OPC_PROG)  begin phase_d = PH_ADDR; op_d = CORE_PROG;      end
              else if (rx_byte == OPC_ER4K)  begin phase_d = PH_ADDR; op_d = CORE_ERASE_4K;  end
              else if (rx_byte == OPC_ER32K) begin phase_d = PH_ADDR; op_d = CORE_ERASE_32K; end
              else if (rx_byte == OPC_ER64K) begin phase_d = PH_ADDR; op_d = CORE_ERASE_64K; end
              else if (rx_byte == OPC_ERALA || rx_byte == OPC_ERALB) begin
                phase_d = PH_ERDY; op_d = CORE_ERASE_ALL;
              end
            end
          end
        end
        PH_STAT: tx_d = sel2_q ? sr2_q : sr1;
        PH_ID: begin
          tx_d = (idx_q == 2'd1) ? TYPE_ID : (idx_q == 2'd2) ? CAP_ID : 8'h00;
          if (idx_q != 2'd3) idx_d = idx_q + 2'd1;
        end
        PH_WRSR: begin
          if (dcnt_q == 2'd0)      begin w1_d = rx_byte[7:2]; dcnt_d = 2'd1; end
          else if (dcnt_q == 2'd1) begin w2_d = rx_byte;      dcnt_d = 2'd2; end
          else phase_d = PH_IGN;
        end
        PH_ADDR: begin
          addr_d = {addr_q[ADDR_W-9:0], rx_byte};
          acnt_d = acnt_q + 1'b1;
          if (acnt_q == ACNT_W'(ADDR_BYTES - 1))
            phase_d = (op_q == CORE_PROG) ? PH_PDATA : PH_ERDY;
        end
        PH_PDATA: begin pv_d = 1'b1; pd_d = rx_byte; dcnt_d = 2'd1; end
        PH_WREN, PH_ERDY: phase_d = PH_IGN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC; op_q <= CORE_PROG; addr_q <= '0; acnt_q <= '0;
      dcnt_q <= '0; sel2_q <= 1'b0; idx_q <= '0; hi_q <= '0; sr2_q <= '0;
      w1_q <= '0; w2_q <= '0; wel_q <= 1'b0; req_q <= 1'b0; tx_q <= '0;
      pv_q <= 1'b0; pd_q <= '0;
    end else begin
      phase_q <= phase_d; op_q <= op_d; addr_q <= addr_d; acnt_q <= acnt_d;
      dcnt_q <= dcnt_d; sel2_q <= sel2_d; idx_q <= idx_d; hi_q <= hi_d; sr2_q <= sr2_d;
      w1_q <= w1_d; w2_q <= w2_d; wel_q <= wel_d; req_q <= req_d; tx_q <= tx_d;
      pv_q <= pv_d; pd_q <= pd_d;
    end
  end

  assign tx_byte   = tx_q;
  assign core_req  = req_q;
  assign core_op   = op_q;
  assign core_addr = addr_q;
  assign pgm_vld   = pv_q;
  assign pgm_data  = pd_q;
  assign wel       = wel_q;

endmodule

// File: rtl/spi_flash_cmd.sv
module spi_flash_cmd
  import spi_flash_cmd_pkg::*;
#(
  parameter int         ADDR_W      = 24,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MFR_ID      = 8'hA7,
  parameter logic [7:0] TYPE_ID     = 8'h40,
  parameter logic [7:0] CAP_ID      = 8'h15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              core_req,
  output logic [2:0]        core_op,
  output logic [ADDR_W-1:0] core_addr,
  input  logic              core_ack,
  input  logic              core_busy,
  output logic              pgm_vld,
  output logic [7:0]        pgm_data
);

  logic       cs_s_w, cs_rise_w, sclk_rise_w, sclk_fall_w, mosi_s_w;
  logic [7:0] rx_byte_w, tx_byte_w;
  logic       rx_done_w, at_bnd_w, wel_w;
  core_op_e   op_w;

  sfc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .cs_s(cs_s_w), .cs_rise(cs_rise_w),
    .sclk_rise(sclk_rise_w), .sclk_fall(sclk_fall_w), .mosi_s(mosi_s_w)
  );

  sfc_byte_io u_io (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s_w), .sclk_rise(sclk_rise_w),
    .sclk_fall(sclk_fall_w), .mosi_s(mosi_s_w), .tx_byte(tx_byte_w),
    .rx_byte(rx_byte_w), .rx_done(rx_done_w), .at_boundary(at_bnd_w),
    .miso(spi_miso)
  );

  sfc_cmd_fsm #(
    .ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .TYPE_ID(TYPE_ID), .CAP_ID(CAP_ID)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s_w), .cs_rise(cs_rise_w),
    .rx_done(rx_done_w), .rx_byte(rx_byte_w), .at_boundary(at_bnd_w),
    .core_busy(core_busy), .core_ack(core_ack), .tx_byte(tx_byte_w),
    .core_req(core_req), .core_op(op_w), .core_addr(core_addr),
    .pgm_vld(pgm_vld), .pgm_data(pgm_data), .wel(wel_w)
  );

  assign core_op = op_w;

endmodule

// File: rtl/spi_flash_cmd_chk.sv
module spi_flash_cmd_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req,
  input logic              core_ack,
  input logic [2:0]        core_op,
  input logic [ADDR_W-1:0] core_addr,
  input logic              pgm_vld,
  input logic              cs_sync,
  input logic              cs_rise,
  input logic              wel
);

  // R12: an unacknowledged request keeps its payload
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && !core_ack |=> core_req && $stable(core_addr) && $stable(core_op));

  // R12: acknowledge releases the request
  p_ack_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && core_ack |=> !core_req);

  // R10: a request appears only as a frame closes
  p_issue_at_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_req) |-> $past(cs_rise));

  // R7: issuing consumes the write-enable latch
  p_wel_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_req) |-> !wel);

  // R8: program bytes only stream inside an open frame
  p_pgm_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_vld |-> !cs_sync);

endmodule

bind spi_flash_cmd spi_flash_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_ack(core_ack),
  .core_op(core_op), .core_addr(core_addr), .pgm_vld(pgm_vld),
  .cs_sync(cs_s_w), .cs_rise(cs_rise_w), .wel(wel_w)
);

// File: tb/spi_flash_cmd_tb_top.sv
`timescale 1ns/1ps
module spi_flash_cmd_tb_top;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, core_req, core_ack = 1'b0, core_busy = 1'b0, pgm_vld;
  logic [2:0]  core_op;
  logic [23:0] core_addr;
  logic [7:0]  pgm_data;

  int vectors = 0;
  int fails = 0;
  int pgm_count = 0;
  logic [7:0] pgm_last = 8'h00;
  logic [7:0] txbuf [16];
  logic [7:0] rxbuf [16];
  logic [7:0] exp_hi = 8'h00;

  always #4 clk = ~clk;

  spi_flash_cmd dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .core_req(core_req),
    .core_op(core_op), .core_addr(core_addr), .core_ack(core_ack),
    .core_busy(core_busy), .pgm_vld(pgm_vld), .pgm_data(pgm_data)
  );

  always @(posedge clk) if (pgm_vld) begin
    pgm_count <= pgm_count + 1;
    pgm_last  <= pgm_data;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  // n full bytes from txbuf, then extra_bits of txbuf[n], then chip-select high
  task automatic run_frame(input int n, input int extra_bits = 0);
    logic [7:0] r;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      spi_bits(txbuf[k], 8, r);
      rxbuf[k] = r;
    end
    if (extra_bits > 0) spi_bits(txbuf[n], extra_bits, r);
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic one_byte(input logic [7:0] opc);
    txbuf[0] = opc;
    run_frame(1);
  endtask

  task automatic read_status(input logic [7:0] opc, output logic [7:0] val);
    txbuf[0] = opc; txbuf[1] = 8'h00;
    run_frame(2);
    val = rxbuf[1];
  endtask

  task automatic ack_req(input string tag);
    @(negedge clk); core_ack = 1'b1;
    @(negedge clk); core_ack = 1'b0;
    repeat (2) @(negedge clk);
    check(tag, core_req, 1'b0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 miso after reset", spi_miso, 1'b0);
    check("R1 core_req after reset", core_req, 1'b0);
    read_status(8'h05, v);
    check("R1 SR1 after reset", v, 8'h00);
    check("R2 miso silent during opcode", rxbuf[0], 8'h00);
    read_status(8'h35, v);
    check("R1 SR2 after reset", v, 8'h00);
  endtask

  task automatic t_wren_status;
    one_byte(8'h06);
    txbuf[0] = 8'h05; txbuf[1] = 8'h00; txbuf[2] = 8'h00; txbuf[3] = 8'h00;
    run_frame(4);
    check("R5 WEL set by 06h", rxbuf[1], 8'h02);
    check("R3 status repeats byte 2", rxbuf[2], 8'h02);
    check("R3 status repeats byte 3", rxbuf[3], 8'h02);
    check("R2 miso idle after frame", spi_miso, 1'b0);
  endtask

  task automatic t_rdid;
    txbuf[0] = 8'h9F;
    for (int k = 1; k < 5; k++) txbuf[k] = 8'h00;
    run_frame(5);
    check("R4 id byte 0", rxbuf[1], 8'hA7);
    check("R4 id byte 1", rxbuf[2], 8'h40);
    check("R4 id byte 2", rxbuf[3], 8'h15);
    check("R4 id past end", rxbuf[4], 8'h00);
  endtask

  task automatic t_wrsr;
    logic [7:0] v;
    txbuf[0] = 8'h01; txbuf[1] = 8'hFE; txbuf[2] = 8'hA5;
    run_frame(3);
    exp_hi = 8'hFC;
    read_status(8'h05, v);
    check("R6 SR1 written, WEL cleared", v, 8'hFC);
    read_status(8'h35, v);
    check("R6 SR2 written", v, 8'hA5);
    txbuf[0] = 8'h01; txbuf[1] = 8'h00; txbuf[2] = 8'h00;
    run_frame(3);
    read_status(8'h05, v);
    check("R6 R9 SR1 kept without WEL", v, 8'hFC);
    read_status(8'h35, v);
    check("R6 SR2 kept without WEL", v, 8'hA5);
  endtask

  task automatic t_erase;
    logic [7:0] opc, v;
    logic [2:0] eop;
    logic [23:0] a;
    for (int k = 0; k < 5; k++) begin
      case (k)
        0: begin opc = 8'h20; eop = 3'd1; end
        1: begin opc = 8'h52; eop = 3'd2; end
        2: begin opc = 8'hD8; eop = 3'd3; end
        3: begin opc = 8'hC7; eop = 3'd4; end
        default: begin opc = 8'h60; eop = 3'd4; end
      endcase
      a = 24'h123456 + 24'(k) * 24'h010101;
      one_byte(8'h06);
      txbuf[0] = opc; txbuf[1] = a[23:16]; txbuf[2] = a[15:8]; txbuf[3] = a[7:0];
      run_frame(k < 3 ? 4 : 1);
      check("R7 erase issued", core_req, 1'b1);
      check("R7 erase op", core_op, eop);
      if (k < 3) check("R7 erase addr", core_addr, a);
      read_status(8'h05, v);
      check("R11 R12 pending shows BUSY, WEL clear", v, exp_hi | 8'h01);
      check("R12 request held before ack", core_req, 1'b1);
      ack_req("R12 request released by ack");
    end
  endtask

  task automatic t_extra;
    logic [7:0] v;
    one_byte(8'h06);
    txbuf[0] = 8'h20; txbuf[1] = 8'h00; txbuf[2] = 8'h10; txbuf[3] = 8'h00; txbuf[4] = 8'h55;
    run_frame(5);
    check("R7 extra byte cancels erase", core_req, 1'b0);
    read_status(8'h05, v);
    check("R7 cancelled erase keeps WEL", v, exp_hi | 8'h02);
  endtask

  task automatic t_program;
    int base;
    base = pgm_count;
    txbuf[0] = 8'h02; txbuf[1] = 8'h00; txbuf[2] = 8'h01; txbuf[3] = 8'h00;
    txbuf[4] = 8'hAB; txbuf[5] = 8'hCD;
    run_frame(6);
    check("R8 data byte strobes", pgm_count - base, 2);
    check("R8 last data byte", pgm_last, 8'hCD);
    check("R8 program issued", core_req, 1'b1);
    check("R8 program op", core_op, 3'd0);
    check("R8 program addr", core_addr, 24'h000100);
    ack_req("R12 program released");
    one_byte(8'h06);
    txbuf[0] = 8'h02; txbuf[1] = 8'h00; txbuf[2] = 8'h02; txbuf[3] = 8'h00;
    run_frame(4);
    check("R8 no data byte no request", core_req, 1'b0);
  endtask

  task automatic t_nowel;
    logic [7:0] v;
    txbuf[0] = 8'h01; txbuf[1] = 8'hFC;
    run_frame(2);
    read_status(8'h05, v);
    check("R6 WEL cleared by status write", v, exp_hi);
    txbuf[0] = 8'h20; txbuf[1] = 8'h00; txbuf[2] = 8'h20; txbuf[3] = 8'h00;
    run_frame(4);
    check("R9 erase without WEL", core_req, 1'b0);
    one_byte(8'hC7);
    check("R9 chip erase without WEL", core_req, 1'b0);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    one_byte(8'h06);
    txbuf[0] = 8'h20; txbuf[1] = 8'h00; txbuf[2] = 8'h30;
    run_frame(3);
    check("R10 short frame no request", core_req, 1'b0);
    txbuf[0] = 8'h20; txbuf[1] = 8'h00; txbuf[2] = 8'h30; txbuf[3] = 8'h00; txbuf[4] = 8'hFF;
    run_frame(4, 3);
    check("R10 mid-byte abort no request", core_req, 1'b0);
    txbuf[0] = 8'hC7; txbuf[1] = 8'hFF;
    run_frame(1, 4);
    check("R10 chip erase mid-byte abort", core_req, 1'b0);
    read_status(8'h05, v);
    check("R10 WEL kept after aborts", v, exp_hi | 8'h02);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    core_busy = 1'b1;
    read_status(8'h05, v);
    check("R11 BUSY bit from core", v, exp_hi | 8'h03);
    txbuf[0] = 8'h9F; txbuf[1] = 8'h00;
    run_frame(2);
    check("R11 id ignored while busy", rxbuf[1], 8'h00);
    txbuf[0] = 8'h20; txbuf[1] = 8'h00; txbuf[2] = 8'h40; txbuf[3] = 8'h00;
    run_frame(4);
    check("R11 erase ignored while busy", core_req, 1'b0);
    core_busy = 1'b0;
    txbuf[0] = 8'h01; txbuf[1] = 8'hFC;
    run_frame(2);
    core_busy = 1'b1;
    one_byte(8'h06);
    core_busy = 1'b0;
    read_status(8'h05, v);
    check("R11 write enable ignored while busy", v, exp_hi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_wren_status();
    t_rdid();
    t_wrsr();
    t_erase();
    t_extra();
    t_program();
    t_nowel();
    t_abort();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule